// File: doc/BRIEF.md
# Serial Character Receiver with Error Flags

This block is the receive half of a serial port. It turns the bit stream on a single data line into 8-bit characters, least significant bit first. It has two timing modes. In oversampled mode a one-cycle pulse arrives at sixteen times the bit rate. The receiver confirms a start bit at the middle of the bit and then samples each later bit at the middle of its bit time. In clocked mode a bit clock comes with the data, and the line is sampled once on every rising edge of that clock.

After the data bits the receiver takes an optional parity bit and then one stop bit. The finished character is copied into a holding register and a ready flag is raised. Sticky flags record three conditions: overrun of unread data, a parity mismatch, and a framing error. A framing error is flagged only for a low stop bit that follows data with at least one bit set, so a line held low (a break) is not flagged as one. Reading the holding register drops the ready flag, and a clear command drops the three error flags. The bit clock, the oversampling pulse and the data line are assumed to be synchronous to the system clock.

Top module: `serial_rx_flags`

## Requirements
- R1: After reset, rx_data is 0 and rx_ready, overrun, parity_err and framing_err are all 0.
- R2: In oversampled mode, a low line at a tick while idle begins a start bit. The line is sampled again on the 8th tick after that. If the line is high there, the start is dropped and no character results.
- R3: In oversampled mode, each later bit is sampled 16 ticks after the previous sample. There are 8 data bits, received least significant bit first.
- R4: In clocked mode (sync_mode=1), the line is sampled on every rising edge of baud_clk. A low sample while idle is the start bit, and the next edge samples data bit 0.
- R5: Frame order is start, 8 data, parity, stop. When parity_mode[2]=1 (no parity), the parity slot is skipped and the stop bit follows data bit 7 directly.
- R6: Two clock cycles after the stop bit is sampled, rx_data holds the character and rx_ready is 1.
- R7: A one-cycle rd_strobe pulse clears rx_ready on the next clock and leaves rx_data unchanged.
- R8: If a character completes while rx_ready is still 1, overrun becomes 1 and rx_data takes the new character.
- R9: parity_mode values 000 (even), 001 (odd), 010 (parity bit must be 0) and 011 (parity bit must be 1) set the expected parity bit. A received parity bit that differs from the expected one sets parity_err.
- R10: framing_err is set when the stop bit is sampled low and at least one data bit is 1. An all-zero character with a low stop bit does not set it.
- R11: A one-cycle clr_status pulse clears overrun, parity_err and framing_err, and does not change rx_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_mode | input | 1 | 1 = clocked mode, 0 = oversampled mode |
| parity_mode | input | 3 | 000 even, 001 odd, 010 bit must be 0, 011 bit must be 1, 1xx no parity bit |
| baud_tick | input | 1 | Oversampling pulse at 16x the bit rate (oversampled mode) |
| baud_clk | input | 1 | Bit clock, sampled on its rising edge (clocked mode) |
| rxd | input | 1 | Serial data line, idles high |
| rd_strobe | input | 1 | Read pulse for the holding register |
| clr_status | input | 1 | Clear pulse for the error flags |
| rx_data | output | 8 | Holding register |
| rx_ready | output | 1 | An unread character is in the holding register |
| overrun | output | 1 | Sticky: a character arrived over unread data |
| parity_err | output | 1 | Sticky: parity mismatch |
| framing_err | output | 1 | Sticky: low stop bit with nonzero data |

## Verification
The stop bit is sampled on the clock edge where the tick or the baud clock rising edge is seen. The completion pulse is registered on that edge, and the holding register and flags update on the next edge. Character results are therefore due two clock edges after the stop sample. A read or clear takes effect on the first edge after its pulse. The driver checks each frame only after the stop bit's full time has passed, at least eight ticks or four clocks later, which is well beyond the two-edge latency. Read and clear results are checked at the falling edge that follows the registering edge.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } rx_state_e;

    // kind[1:0]: 00 even, 01 odd, 10 constant 0, 11 constant 1
    function automatic logic parity_expect(input logic data_xor, input logic [1:0] kind);
        logic p;
        case (kind)
            2'b00:   p = data_xor;
            2'b01:   p = ~data_xor;
            2'b10:   p = 1'b0;
            default: p = 1'b1;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/serial_rx_edge.sv
module serial_rx_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic rise
);
    typedef struct packed {
        logic prev;
    } edge_reg_t;

    edge_reg_t r_q, r_d;

    always_comb begin
        r_d      = r_q;
        r_d.prev = level;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{prev: 1'b1};
        else        r_q <= r_d;
    end

    assign rise = level & ~r_q.prev;

    // a held-high clock gives one sample, not many
    assert_rise_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

endmodule

// File: rtl/serial_rx_framer.sv
module serial_rx_framer
    import serial_rx_pkg::*;
#(
    parameter int DATA_BITS  = 8,
    parameter int OVERSAMPLE = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sync_mode,
    input  logic [2:0]           parity_mode,
    input  logic                 baud_tick,
    input  logic                 baud_rise,
    input  logic                 rxd,
    output logic                 char_done,
    output logic [DATA_BITS-1:0] char_data,
    output logic                 char_par_bad,
    output logic                 char_frm_bad
);
    localparam int CW = $clog2(OVERSAMPLE);
    localparam int IW = $clog2(DATA_BITS);
    localparam logic [CW-1:0] HALF_LAST = CW'(OVERSAMPLE / 2 - 1);
    localparam logic [CW-1:0] FULL_LAST = CW'(OVERSAMPLE - 1);
    localparam logic [IW-1:0] IDX_LAST  = IW'(DATA_BITS - 1);

    typedef struct packed {
        rx_state_e            state;
        logic [CW-1:0]        cnt;
        logic [IW-1:0]        idx;
        logic [DATA_BITS-1:0] shreg;
        logic                 par_bit;
        logic                 done;
        logic [DATA_BITS-1:0] out_data;
        logic                 par_bad;
        logic                 frm_bad;
    } fr_reg_t;

    fr_reg_t r_q, r_d;
    logic    step;
    logic    take;
    logic    no_parity;

    assign step      = sync_mode ? baud_rise : baud_tick;
    assign no_parity = parity_mode[2];

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        take     = 1'b0;
        case (r_q.state)
            ST_IDLE: begin
                if (step && !rxd) begin
                    r_d.cnt   = '0;
                    r_d.idx   = '0;
                    r_d.state = sync_mode ? ST_DATA : ST_START;
                end
            end
            ST_START: begin
                if (step) begin
                    if (r_q.cnt == HALF_LAST) begin
                        r_d.cnt   = '0;
                        r_d.state = rxd ? ST_IDLE : ST_DATA;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
            end
            default: begin
                if (step) begin
                    if (sync_mode || r_q.cnt == FULL_LAST) begin
                        r_d.cnt = '0;
                        take    = 1'b1;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
            end
        endcase

        if (take) begin
            case (r_q.state)
                ST_DATA: begin
                    r_d.shreg = {rxd, r_q.shreg[DATA_BITS-1:1]};
                    r_d.idx   = r_q.idx + 1'b1;
                    if (r_q.idx == IDX_LAST)
                        r_d.state = no_parity ? ST_STOP : ST_PARITY;
                end
                ST_PARITY: begin
                    r_d.par_bit = rxd;
                    r_d.state   = ST_STOP;
                end
                ST_STOP: begin
                    r_d.state    = ST_IDLE;
                    r_d.done     = 1'b1;
                    r_d.out_data = r_q.shreg;
                    r_d.frm_bad  = !rxd && (|r_q.shreg);
                    r_d.par_bad  = !no_parity &&
                        (r_q.par_bit != parity_expect(^r_q.shreg, parity_mode[1:0]));
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{state: ST_IDLE, default: '0};
        else        r_q <= r_d;
    end

    assign char_done    = r_q.done;
    assign char_data    = r_q.out_data;
    assign char_par_bad = r_q.par_bad;
    assign char_frm_bad = r_q.frm_bad;

    assert_false_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_START && baud_tick && !sync_mode && r_q.cnt == HALF_LAST && rxd)
        |=> (r_q.state == ST_IDLE && !r_q.done));

    assert_sync_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_IDLE && sync_mode && baud_rise && !rxd) |=> (r_q.state == ST_DATA));

    assert_break_no_frame_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.done && r_q.out_data == '0) |-> !r_q.frm_bad);

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.done |=> !r_q.done);

endmodule

// File: rtl/serial_rx_status.sv
module serial_rx_status #(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 char_done,
    input  logic [DATA_BITS-1:0] char_data,
    input  logic                 char_par_bad,
    input  logic                 char_frm_bad,
    input  logic                 rd_strobe,
    input  logic                 clr_status,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 rx_ready,
    output logic                 overrun,
    output logic                 parity_err,
    output logic                 framing_err
);
    typedef struct packed {
        logic [DATA_BITS-1:0] data;
        logic                 ready;
        logic                 ovr;
        logic                 par;
        logic                 frm;
    } st_reg_t;

    st_reg_t r_q, r_d;
    logic    ovr_set;

    assign ovr_set = char_done && r_q.ready && !rd_strobe;

    always_comb begin
        r_d = r_q;
        if (char_done) begin
            r_d.data  = char_data;
            r_d.ready = 1'b1;
        end else if (rd_strobe) begin
            r_d.ready = 1'b0;
        end
        r_d.ovr = ovr_set | (r_q.ovr & ~clr_status);
        r_d.par = (char_done & char_par_bad) | (r_q.par & ~clr_status);
        r_d.frm = (char_done & char_frm_bad) | (r_q.frm & ~clr_status);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rx_data     = r_q.data;
    assign rx_ready    = r_q.ready;
    assign overrun     = r_q.ovr;
    assign parity_err  = r_q.par;
    assign framing_err = r_q.frm;

    assert_ready_after_char_R6: assert property (@(posedge clk) disable iff (!rst_n)
        char_done |=> rx_ready);

    assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !char_done) |=> (!rx_ready && $stable(rx_data)));

    assert_overrun_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (char_done && rx_ready && !rd_strobe) |=> overrun);

    assert_clear_flags_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_status && !char_done) |=> (!overrun && !parity_err && !framing_err));

endmodule

// File: rtl/serial_rx_flags.sv
module serial_rx_flags #(
    parameter int DATA_BITS  = 8,
    parameter int OVERSAMPLE = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sync_mode,
    input  logic [2:0]           parity_mode,
    input  logic                 baud_tick,
    input  logic                 baud_clk,
    input  logic                 rxd,
    input  logic                 rd_strobe,
    input  logic                 clr_status,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 rx_ready,
    output logic                 overrun,
    output logic                 parity_err,
    output logic                 framing_err
);
    logic                 baud_rise;
    logic                 char_done;
    logic [DATA_BITS-1:0] char_data;
    logic                 char_par_bad;
    logic                 char_frm_bad;

    serial_rx_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .level (baud_clk),
        .rise  (baud_rise)
    );

    serial_rx_framer #(
        .DATA_BITS  (DATA_BITS),
        .OVERSAMPLE (OVERSAMPLE)
    ) u_framer (
        .clk          (clk),
        .rst_n        (rst_n),
        .sync_mode    (sync_mode),
        .parity_mode  (parity_mode),
        .baud_tick    (baud_tick),
        .baud_rise    (baud_rise),
        .rxd          (rxd),
        .char_done    (char_done),
        .char_data    (char_data),
        .char_par_bad (char_par_bad),
        .char_frm_bad (char_frm_bad)
    );

    serial_rx_status #(
        .DATA_BITS (DATA_BITS)
    ) u_status (
        .clk          (clk),
        .rst_n        (rst_n),
        .char_done    (char_done),
        .char_data    (char_data),
        .char_par_bad (char_par_bad),
        .char_frm_bad (char_frm_bad),
        .rd_strobe    (rd_strobe),
        .clr_status   (clr_status),
        .rx_data      (rx_data),
        .rx_ready     (rx_ready),
        .overrun      (overrun),
        .parity_err   (parity_err),
        .framing_err  (framing_err)
    );

endmodule

// File: tb/serial_rx_flags_tb.sv
module serial_rx_flags_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sync_mode = 1'b0;
    logic [2:0] parity_mode = 3'b000;
    logic       baud_tick = 1'b0;
    logic       baud_clk = 1'b0;
    logic       rxd = 1'b1;
    logic       rd_strobe = 1'b0;
    logic       clr_status = 1'b0;
    logic [7:0] rx_data;
    logic       rx_ready, overrun, parity_err, framing_err;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [7:0] data;
        logic       ready;
        logic       ovr;
        logic       par;
        logic       frm;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    event due_ev;

    // bench model of the holding register and flags
    logic [7:0] m_data = 8'h00;
    logic       m_ready = 1'b0, m_ovr = 1'b0, m_par = 1'b0, m_frm = 1'b0;

    always #4 clk = ~clk;

    serial_rx_flags u_dut (
        .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode), .parity_mode(parity_mode),
        .baud_tick(baud_tick), .baud_clk(baud_clk), .rxd(rxd),
        .rd_strobe(rd_strobe), .clr_status(clr_status),
        .rx_data(rx_data), .rx_ready(rx_ready), .overrun(overrun),
        .parity_err(parity_err), .framing_err(framing_err)
    );

    task automatic compare(input exp_t e);
        checks++;
        if (rx_data !== e.data || rx_ready !== e.ready || overrun !== e.ovr ||
            parity_err !== e.par || framing_err !== e.frm) begin
            errors++;
            $display("FAIL %s: got data=%h rdy=%b ovr=%b par=%b frm=%b exp data=%h rdy=%b ovr=%b par=%b frm=%b",
                     e.tag, rx_data, rx_ready, overrun, parity_err, framing_err,
                     e.data, e.ready, e.ovr, e.par, e.frm);
        end
    endtask

    function automatic exp_t model_item(input string tag);
        exp_t e;
        e.data = m_data; e.ready = m_ready; e.ovr = m_ovr;
        e.par = m_par; e.frm = m_frm; e.tag = tag;
        return e;
    endfunction

    // monitor: pops expected items as each result becomes due
    initial begin
        forever begin
            @(due_ev);
            if (exp_q.size() > 0) compare(exp_q.pop_front());
        end
    end

    task automatic check_now(input string tag);
        compare(model_item(tag));
    endtask

    function automatic logic par_bit_for(input logic [7:0] d, input logic [2:0] pm);
        case (pm[1:0])
            2'b00:   return ^d;
            2'b01:   return ~^d;
            2'b10:   return 1'b0;
            default: return 1'b1;
        endcase
    endfunction

    task automatic bit_async(input logic b, input int nticks);
        rxd = b;
        for (int i = 0; i < nticks; i++) begin
            baud_tick = 1'b1;
            @(negedge clk);
            baud_tick = 1'b0;
            repeat (3) @(negedge clk);
        end
    endtask

    task automatic bit_sync(input logic b);
        rxd = b;
        @(negedge clk); baud_clk = 1'b1;
        repeat (2) @(negedge clk); baud_clk = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // expected-result bookkeeping for one completed character
    task automatic push_char(input logic [7:0] d, input logic pbad, input logic fbad, input string tag);
        m_ovr   = m_ovr | m_ready;
        m_ready = 1'b1;
        m_data  = d;
        m_par   = m_par | pbad;
        m_frm   = m_frm | fbad;
        exp_q.push_back(model_item(tag));
    endtask

    task automatic send_frame(input logic [7:0] d, input logic flip_par, input logic stop_b,
                              input string tag);
        logic pb;
        logic has_par;
        has_par = !parity_mode[2];
        pb = par_bit_for(d, parity_mode) ^ flip_par;
        push_char(d, has_par && flip_par, !stop_b && (|d), tag);
        if (sync_mode) begin
            bit_sync(1'b0);
            for (int i = 0; i < 8; i++) bit_sync(d[i]);
            if (has_par) bit_sync(pb);
            bit_sync(stop_b);
            rxd = 1'b1;
            bit_sync(1'b1);
        end else begin
            bit_async(1'b0, 16);
            for (int i = 0; i < 8; i++) bit_async(d[i], 16);
            if (has_par) bit_async(pb, 16);
            bit_async(stop_b, 16);
            bit_async(1'b1, 4);
        end
        ->due_ev;
        @(negedge clk);
    endtask

    task automatic do_read();
        rd_strobe = 1'b1; @(negedge clk); rd_strobe = 1'b0;
        m_ready = 1'b0;
    endtask

    task automatic do_clear();
        clr_status = 1'b1; @(negedge clk); clr_status = 1'b0;
        m_ovr = 1'b0; m_par = 1'b0; m_frm = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got hung run, expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_now("R1 reset state");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R3 R6 oversampled, even parity
        parity_mode = 3'b000;
        send_frame(8'hA5, 1'b0, 1'b1, "R3 R6 async even A5");
        do_read();
        check_now("R7 read clears ready, data kept");

        // R9 odd parity with corrupted parity bit
        parity_mode = 3'b001;
        send_frame(8'h3C, 1'b1, 1'b1, "R9 odd parity mismatch");
        do_read();
        do_clear();
        check_now("R11 clear drops error flags");

        // R8 overrun: two characters, no read between
        parity_mode = 3'b000;
        send_frame(8'h11, 1'b0, 1'b1, "R8 first char");
        send_frame(8'hE7, 1'b0, 1'b1, "R8 overrun second char");
        do_clear();
        check_now("R11 clear keeps ready");
        do_read();

        // R10 framing error and break
        parity_mode = 3'b100;
        send_frame(8'h3C, 1'b0, 1'b0, "R10 framing error");
        do_read(); do_clear();
        send_frame(8'h00, 1'b0, 1'b0, "R10 break not framing");
        do_read();

        // R5 no parity slot
        send_frame(8'h5A, 1'b0, 1'b1, "R5 no parity");
        do_read();

        // R9 forced parity values
        parity_mode = 3'b011;
        send_frame(8'h81, 1'b0, 1'b1, "R9 constant one ok");
        do_read();
        parity_mode = 3'b010;
        send_frame(8'h81, 1'b1, 1'b1, "R9 constant zero mismatch");
        do_read(); do_clear();

        // R2 short low pulse is not a start
        bit_async(1'b0, 4);
        bit_async(1'b1, 28);
        check_now("R2 false start ignored");
        parity_mode = 3'b000;
        send_frame(8'hC3, 1'b0, 1'b1, "R2 frame after false start");
        do_read();

        // R4 clocked mode
        sync_mode = 1'b1;
        repeat (2) @(negedge clk);
        send_frame(8'h96, 1'b0, 1'b1, "R4 sync even 96");
        do_read();
        parity_mode = 3'b100;
        send_frame(8'h4B, 1'b0, 1'b1, "R4 R5 sync no parity");
        send_frame(8'h70, 1'b0, 1'b0, "R4 R8 R10 sync overrun framing");

        repeat (4) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule